// File: doc/BRIEF.md
# Receive Elastic Buffer with Selectable Pre-Fill

This block carries two-bit receive symbols from a recovered line clock into the local 50 MHz reference clock domain. The two clocks run at nominally the same rate but never match exactly, so a small dual-clock FIFO sits between them. At the start of every frame the FIFO is allowed to collect a number of entries before reading begins. That slack lets the read side run faster or slower than the write side for the whole length of a frame without running dry or overrunning storage.

The amount of slack is chosen by a two-bit mode input. The short setting keeps the added delay low and suits ordinary frame sizes. The long setting holds four more entries, which adds 80 ns at 50 MHz and lets much longer frames survive the same clock offset. Pointers cross between the clock domains in Gray code through two-flop synchronizers. The write side marks the end of each frame with an in-band marker entry, so the read side knows where each frame stops. If storage overruns or the read side runs dry inside a frame, the affected frame's output is flagged as errored and a sticky error flag is raised. Only a reset clears the sticky flag.

Top module: `rx_elastic_buf`

## Requirements
- R1: After reset, rdValid, rdErr and errSticky are all 0.
- R2: Each symbol written while wrValid is high appears once on rdData with rdValid high, in write order, one symbol per read clock, when the clock offset stays within the pre-fill margin. rdErr stays 0 for such a frame.
- R3: If a write finds the buffer full, the symbol is dropped. errSticky becomes 1 and at least one symbol of that frame is delivered with rdErr high.
- R4: If the buffer runs empty inside a frame, the read side still drives rdValid high with rdErr high and rdData 00 for each missing symbol, and errSticky becomes 1.
- R5: Mode code 10 selects a pre-fill of four entries more than the default. With equal clocks, the first output symbol of a frame comes exactly four read cycles later than under code 01.
- R6: Mode codes 00 and 11 behave exactly like code 01, with the same start latency.
- R7: A frame shorter than the selected pre-fill is still delivered completely, once its end has reached the buffer.
- R8: rdValid returns to 0 after the last symbol of a frame. The error mark does not carry into the next frame: a clean frame after an errored one has rdErr at 0 throughout, while errSticky stays 1.
- R9: The write and read Gray pointers change by at most one bit per clock of their own domain.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wrClk | input | 1 | Recovered line clock (write side) |
| wrRstN | input | 1 | Active-low asynchronous reset, write side |
| wrValid | input | 1 | High while frame symbols are presented |
| wrData | input | 2 | Receive symbol from the line |
| rdClk | input | 1 | Local reference clock (read side) |
| rdRstN | input | 1 | Active-low asynchronous reset, read side |
| mode | input | 2 | Pre-fill select: 10 long, any other value default |
| rdValid | output | 1 | Symbol present on rdData |
| rdData | output | 2 | Symbol in the reference domain |
| rdErr | output | 1 | Current symbol belongs to an errored frame |
| errSticky | output | 1 | Overflow or underflow seen since reset |

## Verification
A corrupted pointer or a wrong occupancy count shows up at the ports within one frame. It appears as a missing, repeated or reordered symbol in the delivered stream, as a start latency that is not exactly four cycles apart between the two settings, or as a spurious rdErr. A lost end marker leaves rdValid stuck high after the frame, so it shows within a few dozen read cycles. Pushing the clock offset past the margin in both directions drives the overflow and underflow paths. The symbol count delivered then rises above or falls below the count written.

// File: rtl/rxeb_pkg.sv
package rxeb_pkg;
  localparam int SYM_W = 2;

  typedef struct packed {
    logic             eof;
    logic [SYM_W-1:0] sym;
  } entry_t;

  typedef struct packed {
    logic pop;
    logic emit;
    logic emitErr;
    logic emitFill;
  } strobe_t;
endpackage

// File: rtl/rxeb_gray_sync.sv
module rxeb_gray_sync #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stage1 <= '0;
      q      <= '0;
    end else begin
      stage1 <= d;
      q      <= stage1;
    end
  end
endmodule

// File: rtl/rxeb_datapath.sv
module rxeb_datapath
  import rxeb_pkg::*;
#(
  parameter int ADDR_W = 4,
  localparam int PTR_W = ADDR_W + 1,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic             wrClk,
  input  logic             wrRstN,
  input  logic             wrValid,
  input  logic [SYM_W-1:0] wrData,
  input  logic             rdClk,
  input  logic             rdRstN,
  input  strobe_t          strobe,
  output logic [PTR_W-1:0] occ,
  output entry_t           headEntry,
  output entry_t           lastEntry,
  output logic             ovfPulse,
  output logic             rdValid,
  output logic [SYM_W-1:0] rdData,
  output logic             rdErr,
  output logic [PTR_W-1:0] wrGrayO,
  output logic [PTR_W-1:0] rdGrayO
);
  function automatic logic [PTR_W-1:0] toGray(input logic [PTR_W-1:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [PTR_W-1:0] toBin(input logic [PTR_W-1:0] g);
    logic [PTR_W-1:0] b;
    b[PTR_W-1] = g[PTR_W-1];
    for (int i = PTR_W - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  entry_t mem [DEPTH];

  // write domain
  logic [PTR_W-1:0] wrBin, wrGray, rdGraySync;
  logic prevValid, eofPend, ovfToggle;
  logic full, wantEof, doWrite;
  entry_t wrEntry;

  rxeb_gray_sync #(.W(PTR_W)) u_syncRd (
    .clk(wrClk), .rstN(wrRstN), .d(rdGrayO), .q(rdGraySync)
  );

  assign full    = wrGray == {~rdGraySync[PTR_W-1:PTR_W-2], rdGraySync[PTR_W-3:0]};
  assign wantEof = eofPend | (prevValid & ~wrValid);

  always_comb begin
    doWrite = 1'b0;
    wrEntry = '{eof: 1'b0, sym: wrData};
    if (wantEof) begin
      wrEntry = '{eof: 1'b1, sym: '0};
      doWrite = ~full;
    end else if (wrValid) begin
      doWrite = ~full;
    end
  end

  always_ff @(posedge wrClk) begin
    if (doWrite) mem[wrBin[ADDR_W-1:0]] <= wrEntry;
  end

  always_ff @(posedge wrClk or negedge wrRstN) begin
    if (!wrRstN) begin
      wrBin     <= '0;
      wrGray    <= '0;
      prevValid <= 1'b0;
      eofPend   <= 1'b0;
      ovfToggle <= 1'b0;
    end else begin
      prevValid <= wrValid;
      if (doWrite) begin
        wrBin  <= wrBin + 1'b1;
        wrGray <= toGray(wrBin + 1'b1);
      end
      if (wantEof) eofPend <= full;
      // a symbol with no room, or displaced by a pending end marker, is lost
      if (wrValid && (full || wantEof)) ovfToggle <= ~ovfToggle;
    end
  end

  assign wrGrayO = wrGray;

  // read domain
  logic [PTR_W-1:0] rdBin, rdGray, wrGraySync, wrBinSync;
  logic ovfSync, ovfSyncD;

  rxeb_gray_sync #(.W(PTR_W)) u_syncWr (
    .clk(rdClk), .rstN(rdRstN), .d(wrGray), .q(wrGraySync)
  );
  rxeb_gray_sync #(.W(1)) u_syncOvf (
    .clk(rdClk), .rstN(rdRstN), .d(ovfToggle), .q(ovfSync)
  );

  assign wrBinSync = toBin(wrGraySync);
  assign occ       = wrBinSync - rdBin;
  assign headEntry = mem[rdBin[ADDR_W-1:0]];
  assign lastEntry = mem[ADDR_W'(wrBinSync[ADDR_W-1:0] - 1'b1)];
  assign ovfPulse  = ovfSync ^ ovfSyncD;

  always_ff @(posedge rdClk or negedge rdRstN) begin
    if (!rdRstN) begin
      rdBin    <= '0;
      rdGray   <= '0;
      ovfSyncD <= 1'b0;
      rdValid  <= 1'b0;
      rdErr    <= 1'b0;
      rdData   <= '0;
    end else begin
      ovfSyncD <= ovfSync;
      if (strobe.pop) begin
        rdBin  <= rdBin + 1'b1;
        rdGray <= toGray(rdBin + 1'b1);
      end
      rdValid <= strobe.emit;
      rdErr   <= strobe.emit & strobe.emitErr;
      rdData  <= (strobe.emit && !strobe.emitFill) ? headEntry.sym : '0;
    end
  end

  assign rdGrayO = rdGray;
endmodule

// File: rtl/rxeb_read_ctrl.sv
module rxeb_read_ctrl
  import rxeb_pkg::*;
#(
  parameter int PTR_W      = 5,
  parameter int BASE_FILL  = 4,
  parameter int EXTRA_FILL = 4
) (
  input  logic             rdClk,
  input  logic             rdRstN,
  input  logic [1:0]       mode,
  input  logic [PTR_W-1:0] occ,
  input  entry_t           headEntry,
  input  entry_t           lastEntry,
  input  logic             ovfPulse,
  output strobe_t          strobe,
  output logic             errSticky
);
  localparam logic [PTR_W-1:0] NEED_SHORT = PTR_W'(BASE_FILL);
  localparam logic [PTR_W-1:0] NEED_LONG  = PTR_W'(BASE_FILL + EXTRA_FILL);

  typedef enum logic {IDLE, STREAM} state_t;
  state_t state;
  logic frameErr;
  logic [PTR_W-1:0] need;
  logic empty, startGo;

  assign need    = (mode == 2'b10) ? NEED_LONG : NEED_SHORT;
  assign empty   = occ == '0;
  assign startGo = (occ >= need) || (!empty && lastEntry.eof);

  always_comb begin
    strobe = '0;
    if (state == STREAM) begin
      if (empty) begin
        strobe.emit     = 1'b1;
        strobe.emitErr  = 1'b1;
        strobe.emitFill = 1'b1;
      end else if (headEntry.eof) begin
        strobe.pop = 1'b1;
      end else begin
        strobe.pop     = 1'b1;
        strobe.emit    = 1'b1;
        strobe.emitErr = frameErr | ovfPulse;
      end
    end
  end

  always_ff @(posedge rdClk or negedge rdRstN) begin
    if (!rdRstN) begin
      state     <= IDLE;
      frameErr  <= 1'b0;
      errSticky <= 1'b0;
    end else begin
      case (state)
        IDLE:   if (startGo) state <= STREAM;
        STREAM: begin
          if (empty) begin
            frameErr  <= 1'b1;
            errSticky <= 1'b1;
          end else if (headEntry.eof) begin
            frameErr <= 1'b0;
            state    <= IDLE;
          end
        end
        default: state <= IDLE;
      endcase
      if (ovfPulse) begin
        frameErr  <= 1'b1;
        errSticky <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/rx_elastic_buf.sv
module rx_elastic_buf
  import rxeb_pkg::*;
#(
  parameter int ADDR_W     = 4,
  parameter int BASE_FILL  = 4,
  parameter int EXTRA_FILL = 4,
  localparam int PTR_W     = ADDR_W + 1
) (
  input  logic             wrClk,
  input  logic             wrRstN,
  input  logic             wrValid,
  input  logic [SYM_W-1:0] wrData,
  input  logic             rdClk,
  input  logic             rdRstN,
  input  logic [1:0]       mode,
  output logic             rdValid,
  output logic [SYM_W-1:0] rdData,
  output logic             rdErr,
  output logic             errSticky
);
  strobe_t          strobe;
  logic [PTR_W-1:0] occ, wrGrayW, rdGrayW;
  entry_t           headEntry, lastEntry;
  logic             ovfPulse;

  rxeb_datapath #(.ADDR_W(ADDR_W)) u_dp (
    .wrClk(wrClk), .wrRstN(wrRstN), .wrValid(wrValid), .wrData(wrData),
    .rdClk(rdClk), .rdRstN(rdRstN), .strobe(strobe), .occ(occ),
    .headEntry(headEntry), .lastEntry(lastEntry), .ovfPulse(ovfPulse),
    .rdValid(rdValid), .rdData(rdData), .rdErr(rdErr),
    .wrGrayO(wrGrayW), .rdGrayO(rdGrayW)
  );

  rxeb_read_ctrl #(.PTR_W(PTR_W), .BASE_FILL(BASE_FILL), .EXTRA_FILL(EXTRA_FILL)) u_ctrl (
    .rdClk(rdClk), .rdRstN(rdRstN), .mode(mode), .occ(occ),
    .headEntry(headEntry), .lastEntry(lastEntry), .ovfPulse(ovfPulse),
    .strobe(strobe), .errSticky(errSticky)
  );
endmodule

// File: rtl/rxeb_checker.sv
module rxeb_checker #(
  parameter int PTR_W = 5
) (
  input logic             wrClk,
  input logic             wrRstN,
  input logic             rdClk,
  input logic             rdRstN,
  input logic [PTR_W-1:0] wrGray,
  input logic [PTR_W-1:0] rdGray,
  input logic             rdValid,
  input logic             rdErr,
  input logic             errSticky
);
  assert_wr_gray_step_R9: assert property (@(posedge wrClk) disable iff (!wrRstN)
    $onehot0(wrGray ^ $past(wrGray)));

  assert_rd_gray_step_R9: assert property (@(posedge rdClk) disable iff (!rdRstN)
    $onehot0(rdGray ^ $past(rdGray)));

  assert_sticky_holds_R3: assert property (@(posedge rdClk) disable iff (!rdRstN)
    errSticky |=> errSticky);

  assert_err_needs_valid_R4: assert property (@(posedge rdClk) disable iff (!rdRstN)
    rdErr |-> rdValid);

  assert_err_flags_sticky_R3: assert property (@(posedge rdClk) disable iff (!rdRstN)
    rdErr |-> errSticky);
endmodule

bind rx_elastic_buf rxeb_checker #(.PTR_W(PTR_W)) u_chk (
  .wrClk(wrClk), .wrRstN(wrRstN), .rdClk(rdClk), .rdRstN(rdRstN),
  .wrGray(wrGrayW), .rdGray(rdGrayW), .rdValid(rdValid), .rdErr(rdErr),
  .errSticky(errSticky)
);

// File: tb/rx_elastic_buf_tb.sv
`timescale 1ns/100ps
module rx_elastic_buf_tb;
  localparam int CLK_PERIOD = 20;
  localparam int NVEC = 9;

  typedef struct packed {
    logic [1:0] mode;
    int         len;
    int         wrPer;
    logic       expErr;
  } vec_t;

  // vectors 0..3: equal clocks for latency; 4,5: small offset; 6: short frame;
  // 7: underflow; 8: overflow
  localparam vec_t VEC [NVEC] = '{
    '{2'b01, 20, 20, 1'b0},
    '{2'b10, 20, 20, 1'b0},
    '{2'b00, 20, 20, 1'b0},
    '{2'b11, 20, 20, 1'b0},
    '{2'b01, 40, 19, 1'b0},
    '{2'b10, 40, 21, 1'b0},
    '{2'b10,  2, 20, 1'b0},
    '{2'b01, 60, 24, 1'b1},
    '{2'b10, 100, 16, 1'b1}
  };

  logic wrClk = 0, rdClk = 0, rstN = 0;
  logic wrValid = 0;
  logic [1:0] wrData = 0, mode = 2'b01;
  logic rdValid, rdErr, errSticky;
  logic [1:0] rdData;

  real wrHalf = 10.0;
  int checks = 0, errors = 0, rdCycle = 0;
  int capCnt = 0, firstCycle = 0, startCycle = 0;
  logic capErr = 0;
  logic [1:0] capData [256];
  int lat [4];
  bit done = 0;

  rx_elastic_buf u_dut (
    .wrClk(wrClk), .wrRstN(rstN), .wrValid(wrValid), .wrData(wrData),
    .rdClk(rdClk), .rdRstN(rstN), .mode(mode),
    .rdValid(rdValid), .rdData(rdData), .rdErr(rdErr), .errSticky(errSticky)
  );

  always #(CLK_PERIOD/2) rdClk = ~rdClk;
  initial begin
    #5;
    forever #(wrHalf) wrClk = ~wrClk;
  end

  always @(posedge rdClk) rdCycle++;

  always @(negedge rdClk) begin
    if (rdValid) begin
      if (capCnt == 0) firstCycle = rdCycle;
      if (capCnt < 256) capData[capCnt] = rdData;
      capCnt++;
      capErr = capErr | rdErr;
    end
  end

  function automatic logic [1:0] dib(int i);
    return 2'((i * 7 + i / 3) % 4);
  endfunction

  task automatic check(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic doReset();
    rstN = 0;
    wrValid = 0;
    repeat (4) @(posedge rdClk);
    #1 rstN = 1;
    repeat (4) @(posedge rdClk);
  endtask

  task automatic sendFrame(int len);
    capCnt = 0;
    capErr = 0;
    for (int i = 0; i < len; i++) begin
      @(posedge wrClk);
      #1;
      if (i == 0) startCycle = rdCycle;
      wrValid = 1;
      wrData = dib(i);
    end
    @(posedge wrClk);
    #1 wrValid = 0;
  endtask

  task automatic waitQuiet();
    int quiet = 0;
    while (quiet < 40) begin
      @(negedge rdClk);
      if (rdValid) quiet = 0; else quiet++;
    end
  endtask

  task automatic checkStream(int len, string tag);
    int bad = 0;
    check(capCnt == len, {tag, " symbol count"}, capCnt, len);
    for (int i = 0; i < len && i < 256; i++)
      if (capData[i] !== dib(i)) bad++;
    check(bad == 0, {tag, " symbol order/value mismatches"}, bad, 0);
  endtask

  initial begin
    doReset();
    @(negedge rdClk);
    // R1: reset state
    check(rdValid == 0, "R1 rdValid after reset", rdValid, 0);
    check(rdErr == 0, "R1 rdErr after reset", rdErr, 0);
    check(errSticky == 0, "R1 errSticky after reset", errSticky, 0);

    for (int v = 0; v < NVEC; v++) begin
      doReset();
      mode = VEC[v].mode;
      wrHalf = VEC[v].wrPer / 2.0;
      repeat (3) @(posedge rdClk);
      sendFrame(VEC[v].len);
      waitQuiet();
      if (v < 4) lat[v] = firstCycle - startCycle;
      check(rdValid == 0, "R8 rdValid low after frame", rdValid, 0);
      check(errSticky == VEC[v].expErr, "R3/R4 errSticky after frame", errSticky, VEC[v].expErr);
      check(capErr == VEC[v].expErr, "R3/R4 rdErr seen in frame", capErr, VEC[v].expErr);
      if (!VEC[v].expErr)
        checkStream(VEC[v].len, v == 6 ? "R7 short frame" : "R2 in-order delivery");
      if (v == 7) check(capCnt > VEC[v].len, "R4 fill symbols inserted", capCnt, VEC[v].len + 1);
      if (v == 8) check(capCnt < VEC[v].len, "R3 symbols dropped", capCnt, VEC[v].len - 1);
    end

    check(lat[0] >= 4, "R5 default start latency covers pre-fill", lat[0], 4);
    check(lat[1] == lat[0] + 4, "R5 long mode extra latency", lat[1], lat[0] + 4);
    check(lat[2] == lat[0], "R6 mode 00 latency", lat[2], lat[0]);
    check(lat[3] == lat[0], "R6 mode 11 latency", lat[3], lat[0]);

    // R8 / R3: errored frame then clean frame without reset
    doReset();
    mode = 2'b10;
    wrHalf = 8.0;
    sendFrame(100);
    waitQuiet();
    check(errSticky == 1, "R3 overflow sets sticky", errSticky, 1);
    wrHalf = 10.0;
    mode = 2'b01;
    repeat (3) @(posedge rdClk);
    sendFrame(30);
    waitQuiet();
    check(errSticky == 1, "R3 sticky survives clean frame", errSticky, 1);
    check(capErr == 0, "R8 error mark cleared for next frame", capErr, 0);
    checkStream(30, "R8 clean frame after error");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule